// File: doc/BRIEF.md
# Reference Counter with Stamp Snapshot

This block keeps a free-running reference count that advances by one on every cycle in which its count-enable input is high. A host can read the count at any time through a byte-wide read port. It can also read a second register, the snapshot, which holds the count at the moment of the most recent accepted stamp event. Stamp events come from a stream parser outside this block.

A stamp event is accepted only when two conditions hold. The host must have issued an arm command at some earlier cycle since reset, and the stamp interrupt enable input must be high. Each accepted stamp produces a one-cycle pulse toward the interrupt logic. Once set, the arm remains in force until reset, so every later qualified stamp also captures.

Both registers are presented as a set of bytes, least significant byte first. Reading the lowest live byte also copies the whole live count into a hold register, which keeps a multi-byte read consistent while the count moves on.

Top module: `refstamp_counter`

## Requirements
- R1: During and right after synchronous active-low reset, the live count and the snapshot are 0, the block is not armed, `stamp_irq` is 0 and `rd_data` is 0.
- R2: The live count increases by one at each clock edge where `tick` is high, and keeps its value at each edge where `tick` is low.
- R3: When the count is at its maximum (2^CNT_W−1) and `tick` is high, it goes to 0 without any other effect.
- R4: A high `arm_wr` at an edge arms the block from the next cycle on and does not change the live count. The block stays armed until reset.
- R5: A stamp is captured at an edge where `stamp_evt` is high, the block is already armed, and `stamp_ie` is high. The snapshot then takes the live count held just before that edge.
- R6: The snapshot does not change at any edge where the block is not yet armed or `stamp_ie` is low. This includes the edge at which `arm_wr` itself is first high.
- R7: `stamp_irq` is high for exactly the one cycle after each capture, and low otherwise.
- R8: Reads are registered. `rd_data` takes the addressed byte one cycle after an edge with `rd_en` high, and keeps its value when `rd_en` is low.
- R9: The live count occupies addresses 0 to NB−1, where NB = ceil(CNT_W/8). Address k holds count bits 8k+7..8k, with unused upper bits read as 0. With CNT_W=33, address 4 holds bit 32 in bit 0.
- R10: A read of address 0 returns the current low byte and copies the whole live count into a hold register. Reads of addresses 1 to NB−1 return bytes of that held copy, not of the moving count.
- R11: The snapshot occupies addresses 8 to 8+NB−1, using the same byte layout as the live count.
- R12: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable for the live counter |
| arm_wr | input | 1 | Host arm command, one cycle |
| stamp_ie | input | 1 | Stamp interrupt enable bit |
| stamp_evt | input | 1 | Stamp detected, one cycle |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 8 | Registered read byte |
| stamp_irq | output | 1 | One-cycle capture pulse to the interrupt logic |

## Verification
Two copies of the block run on the same stimulus, one 33 bits wide and one 10 bits wide. This lets the narrow copy wrap many times in a short run while the wide copy checks the five-byte layout. Directed sequences separate three stamp cases: a stamp before any arm, a stamp on the very edge of the arm command, and a stamp with the enable low. Each must leave the snapshot untouched, while a fully qualified stamp must capture and pulse. Random traffic mixes gaps in `tick` with reads at random addresses. This exposes the difference between the held upper bytes and the live count, and confirms that unmapped addresses read zero. A second reset near the end confirms that the arm is cleared.

// File: rtl/refstamp_pkg.sv
// Package: shared address map and read-region decode for the reference
// counter. Assumes at most 8 bytes per register, so that live and snapshot
// windows do not overlap.
package refstamp_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam logic [ADDR_W-1:0] SNAP_BASE = 4'd8;

    typedef enum logic [1:0] {
        REG_LIVE_LO   = 2'd0,
        REG_LIVE_HELD = 2'd1,
        REG_SNAP      = 2'd2,
        REG_NONE      = 2'd3
    } rd_region_e;

    // Classify a byte address for a register of nb bytes.
    function automatic rd_region_e classify(input logic [ADDR_W-1:0] a,
                                            input int unsigned nb);
        int unsigned ai;
        int unsigned sb;
        ai = 32'(a);
        sb = 32'(SNAP_BASE);
        if (ai == 0)
            return REG_LIVE_LO;
        else if (ai < nb)
            return REG_LIVE_HELD;
        else if (ai >= sb && ai < sb + nb)
            return REG_SNAP;
        else
            return REG_NONE;
    endfunction

endpackage

// File: rtl/refcnt_core.sv
// Module: free-running reference counter.
// Advances by one on each edge with tick high and wraps silently at
// 2^CNT_W-1. Assumes a synchronous active-low reset.
module refcnt_core #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    // Count up on each enabled cycle; the natural overflow gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + CNT_W'(1);
    end

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count == CNT_W'($past(count) + CNT_W'(1)));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

endmodule

// File: rtl/stamp_latch.sv
// Module: arm flag, stamp snapshot register and capture pulse.
// A capture needs a previously registered arm command and the enable bit.
// The arm is sticky until reset. Assumes stamp_evt is already synchronous.
module stamp_latch #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_wr,
    input  logic             stamp_ie,
    input  logic             stamp_evt,
    input  logic [CNT_W-1:0] live_cnt,
    output logic [CNT_W-1:0] snap,
    output logic             stamp_irq
);

    logic armed;
    logic take;

    // A stamp qualifies only when it arrives armed and enabled.
    always_comb take = stamp_evt && armed && stamp_ie;

    // The arm flag is set by the host command and held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (arm_wr)
            armed <= 1'b1;
    end

    // Snapshot register and the one-cycle capture pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap      <= '0;
            stamp_irq <= 1'b0;
        end else begin
            stamp_irq <= take;
            if (take)
                snap <= live_cnt;
        end
    end

    a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    a_r4_arm_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(arm_wr));

    a_r6_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(snap));

    a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !stamp_ie |=> $stable(snap));

    a_r7_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_irq |-> $past(stamp_evt && stamp_ie));

    a_r5_captured_value: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_irq |-> snap == $past(live_cnt));

endmodule

// File: rtl/byte_reader.sv
// Module: byte-wide host read port for the live count and the snapshot.
// A read of address 0 copies the live count into a hold register, so the
// upper bytes read afterwards are consistent with it. The output is
// registered and holds its value between reads.
module byte_reader
    import refstamp_pkg::*;
#(
    parameter int CNT_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic [CNT_W-1:0]  snap,
    output logic [7:0]        rd_data
);

    localparam int NBYTES = (CNT_W + 7) / 8;
    localparam int PAD_W  = NBYTES * 8;

    logic [CNT_W-1:0]  held;
    logic [PAD_W-1:0]  live_pad, held_pad, snap_pad;
    logic [7:0]        live_b [NBYTES];
    logic [7:0]        held_b [NBYTES];
    logic [7:0]        snap_b [NBYTES];
    rd_region_e        region;
    logic [ADDR_W-1:0] snap_idx;
    logic [7:0]        held_sel, snap_sel, next_byte;

    // Zero-extend each register to whole bytes.
    always_comb begin
        live_pad = PAD_W'(live_cnt);
        held_pad = PAD_W'(held);
        snap_pad = PAD_W'(snap);
    end

    // Split each padded register into byte lanes.
    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        always_comb begin
            live_b[k] = live_pad[8*k +: 8];
            held_b[k] = held_pad[8*k +: 8];
            snap_b[k] = snap_pad[8*k +: 8];
        end
    end

    // Decode the address into a region and a byte index.
    always_comb begin
        region   = classify(rd_addr, NBYTES);
        snap_idx = rd_addr - SNAP_BASE;
    end

    // Pick the addressed byte of the held copy and of the snapshot.
    always_comb begin
        held_sel = 8'd0;
        snap_sel = 8'd0;
        for (int k = 0; k < NBYTES; k++) begin
            if (rd_addr == ADDR_W'(k))
                held_sel = held_b[k];
            if (snap_idx == ADDR_W'(k))
                snap_sel = snap_b[k];
        end
    end

    // Final read mux across the regions.
    always_comb begin
        unique case (region)
            REG_LIVE_LO:   next_byte = live_b[0];
            REG_LIVE_HELD: next_byte = held_sel;
            REG_SNAP:      next_byte = snap_sel;
            default:       next_byte = 8'd0;
        endcase
    end

    // Hold register, loaded on a read of the low live byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (rd_en && region == REG_LIVE_LO)
            held <= live_cnt;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'd0;
        else if (rd_en)
            rd_data <= next_byte;
    end

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r10_low_byte_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0) |=> rd_data == $past(live_cnt[7:0]));

    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr > ADDR_W'(NBYTES - 1) && rd_addr < SNAP_BASE) |=> rd_data == 8'd0);

endmodule

// File: rtl/refstamp_counter.sv
// Module: top of the reference counter with stamp snapshot.
// It joins the counter, the stamp latch and the byte read port.
// Assumes all inputs are synchronous to clk and the reset is synchronous
// active low.
module refstamp_counter
    import refstamp_pkg::*;
#(
    parameter int CNT_W = 33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              arm_wr,
    input  logic              stamp_ie,
    input  logic              stamp_evt,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              stamp_irq
);

    logic [CNT_W-1:0] live_cnt;
    logic [CNT_W-1:0] snap;

    refcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (live_cnt)
    );

    stamp_latch #(.CNT_W(CNT_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm_wr    (arm_wr),
        .stamp_ie  (stamp_ie),
        .stamp_evt (stamp_evt),
        .live_cnt  (live_cnt),
        .snap      (snap),
        .stamp_irq (stamp_irq)
    );

    byte_reader #(.CNT_W(CNT_W)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .live_cnt (live_cnt),
        .snap     (snap),
        .rd_data  (rd_data)
    );

    a_r4_arm_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && !tick) |=> $stable(live_cnt));

endmodule

// File: tb/test_refstamp_counter.sv
// Bench: two widths driven by the same stimulus, each checked against
// its own reference model.
module test_refstamp_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, arm_wr = 1'b0, stamp_ie = 1'b0, stamp_evt = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_a, rd_b;
    logic       irq_a, irq_b;

    int n_cmp = 0;
    int n_bad = 0;
    string force_tag = "";

    always #2.5 clk = ~clk;

    refstamp_counter #(.CNT_W(33)) i_refstamp_counter (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm_wr(arm_wr),
        .stamp_ie(stamp_ie), .stamp_evt(stamp_evt), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_a), .stamp_irq(irq_a));

    refstamp_counter #(.CNT_W(10)) i_refstamp_counter_narrow (
        .clk(clk), .rst_n(rst_n), .tick(tick), .arm_wr(arm_wr),
        .stamp_ie(stamp_ie), .stamp_evt(stamp_evt), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_b), .stamp_irq(irq_b));

    // Reference model state, one slot per instance.
    int          wid   [2] = '{33, 10};
    logic [39:0] m_cnt [2], m_snap [2], m_held [2];
    logic        m_arm [2];
    logic [7:0]  e_rd  [2];
    logic        e_irq [2];
    string       e_tag [2];

    function automatic int nbytes(int i);
        return (wid[i] + 7) / 8;
    endfunction

    function automatic logic [39:0] wmask(int i);
        return (40'd1 << wid[i]) - 40'd1;
    endfunction

    // Expected byte at an address, from the map in R9, R10, R11 and R12.
    function automatic logic [7:0] model_byte(int i, int a);
        int nb = nbytes(i);
        if (a == 0) return m_cnt[i][7:0];
        if (a < nb) return m_held[i][8*a +: 8];
        if (a >= 8 && a < 8 + nb) return m_snap[i][8*(a-8) +: 8];
        return 8'd0;
    endfunction

    function automatic string tag_for(int i, int a);
        int nb = nbytes(i);
        if (a == 0) return "R10";
        if (a < nb) return "R9";
        if (a >= 8 && a < 8 + nb) return "R11";
        return "R12";
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cnt[i] = '0; m_snap[i] = '0; m_held[i] = '0;
            m_arm[i] = 1'b0; e_rd[i] = 8'd0; e_irq[i] = 1'b0; e_tag[i] = "R1";
        end
    endtask

    // Advance the model by one edge using the inputs now applied, then
    // move to the falling edge after that rising edge.
    task automatic step();
        for (int i = 0; i < 2; i++) begin
            logic take;
            take = stamp_evt && m_arm[i] && stamp_ie;
            if (rd_en) begin
                e_rd[i]  = model_byte(i, int'(rd_addr));
                e_tag[i] = tag_for(i, int'(rd_addr));
            end else begin
                e_tag[i] = "R8";
            end
            if (rd_en && rd_addr == 4'd0) m_held[i] = m_cnt[i];
            e_irq[i] = take;
            if (take) m_snap[i] = m_cnt[i];
            if (arm_wr) m_arm[i] = 1'b1;
            if (tick) m_cnt[i] = (m_cnt[i] + 40'd1) & wmask(i);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_now();
        for (int i = 0; i < 2; i++) begin
            logic [7:0] got_rd;
            logic       got_irq;
            string      t;
            got_rd  = (i == 0) ? rd_a : rd_b;
            got_irq = (i == 0) ? irq_a : irq_b;
            t = (force_tag != "") ? force_tag : e_tag[i];
            n_cmp++;
            if (got_rd !== e_rd[i]) begin
                n_bad++;
                $display("FAIL %s width %0d rd_data got %02h expected %02h at %0t",
                         t, wid[i], got_rd, e_rd[i], $time);
            end
            n_cmp++;
            if (got_irq !== e_irq[i]) begin
                n_bad++;
                $display("FAIL %s width %0d stamp_irq got %0b expected %0b at %0t",
                         (force_tag != "") ? force_tag : "R7", wid[i], got_irq, e_irq[i], $time);
            end
        end
    endtask

    task automatic cyc();
        step();
        check_now();
    endtask

    task automatic idle_inputs();
        tick = 0; arm_wr = 0; stamp_evt = 0; rd_en = 0; rd_addr = 0;
    endtask

    // Read every byte of both registers for both widths.
    task automatic read_all(string t);
        force_tag = t;
        for (int a = 0; a < 16; a++) begin
            rd_en = 1; rd_addr = 4'(a);
            cyc();
        end
        rd_en = 0;
        force_tag = "";
    endtask

    task automatic do_reset();
        idle_inputs();
        stamp_ie = 0;
        rst_n = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        model_reset();
        rst_n = 1;
    endtask

    initial begin
        #500us;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R1: reset state readback.
        force_tag = "R1"; check_now(); force_tag = "";
        read_all("R1");

        // R2: counting with gaps in tick.
        tick = 1; for (int k = 0; k < 5; k++) cyc();
        tick = 0; for (int k = 0; k < 3; k++) cyc();
        read_all("R2");

        // R6: stamp while unarmed with enable high.
        stamp_ie = 1; stamp_evt = 1; tick = 1;
        force_tag = "R6"; cyc(); force_tag = "";
        stamp_evt = 0; tick = 0;
        read_all("R6");

        // R4 and R6: arm with tick low, stamp on the same edge.
        arm_wr = 1; stamp_evt = 1;
        force_tag = "R4"; cyc();
        arm_wr = 0; stamp_evt = 0;
        cyc(); force_tag = "";
        read_all("R4");

        // R6: armed but enable low.
        stamp_ie = 0; stamp_evt = 1; tick = 1;
        force_tag = "R6"; cyc(); force_tag = "";
        stamp_evt = 0; tick = 0;
        read_all("R6");

        // R5 and R7: qualified stamp, then a later one (arm stays set).
        for (int s = 0; s < 2; s++) begin
            stamp_ie = 1; tick = 1;
            for (int k = 0; k < 7; k++) cyc();
            stamp_evt = 1;
            force_tag = "R5"; cyc();
            stamp_evt = 0;
            force_tag = "R7"; cyc(); cyc(); force_tag = "";
            tick = 0;
            read_all("R5");
        end

        // R3: run the narrow counter across its wrap.
        tick = 1;
        for (int k = 0; k < 1100; k++) cyc();
        tick = 0;
        read_all("R3");

        // R10: low-byte read, then the count moves, then upper bytes read.
        tick = 1;
        rd_en = 1; rd_addr = 0; cyc();
        rd_en = 0; for (int k = 0; k < 300; k++) cyc();
        force_tag = "R10";
        for (int a = 1; a < 5; a++) begin rd_en = 1; rd_addr = 4'(a); cyc(); end
        force_tag = "";
        rd_en = 0; tick = 0;

        // Random traffic.
        for (int k = 0; k < 4000; k++) begin
            tick      = ($urandom_range(3) != 0);
            stamp_evt = ($urandom_range(9) == 0);
            if ($urandom_range(49) == 0) stamp_ie = ~stamp_ie;
            rd_en     = ($urandom_range(2) != 0);
            rd_addr   = 4'($urandom_range(15));
            cyc();
        end
        idle_inputs();

        // R4 and R1: reset clears the arm; a stamp afterwards must not capture.
        do_reset();
        stamp_ie = 1; stamp_evt = 1; tick = 1;
        force_tag = "R4"; cyc(); force_tag = "";
        stamp_evt = 0; tick = 0;
        read_all("R4");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule